// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that encodes the kind of each bus transfer on three status lines instead of driving its own strobes. It watches those lines and, when they leave the all-ones passive code for an active code, runs one bus cycle. The cycle drives the address latch pulse, the data buffer enable and the data direction, and raises the command strobe that matches the latched code. All outputs are active high. Reset is asynchronous and active low.

A cycle is tracked by a state machine with five named states. IDLE waits for a start. The transition IDLE->T1 (and T4->T1) is taken when the previous status sample was passive (111) and the current one is an active code other than halt (011); the code is latched at that edge. T1 (latch pulse) always moves to T2, or to T4 if the status is already passive again. T2 (early strobes) moves to T3, or to T4 on passive. T3 (full strobes) stays in T3 as a wait state while the status stays active and moves to T4 when it turns passive. T4 (buffer release) returns to IDLE, or goes straight to T1 if a new start is seen.

Codes: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 instruction fetch, 101 memory read, 110 memory write, 111 passive.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: The latched code picks the strobe: 000 raises cmd_inta, 001 cmd_io_rd, 010 cmd_io_wr and cmd_io_wr_adv, 100 and 101 cmd_mem_rd, 110 cmd_mem_wr and cmd_mem_wr_adv; at most one strobe group is high at any time.
- R2: On the first clock edge where the status is active (not 111, not 011) after having been 111 at the previous edge, addr_latch is high for exactly the next clock (T1).
- R3: cmd_inta, cmd_io_rd, cmd_mem_rd and both advanced write strobes are high in T2 and T3 only.
- R4: cmd_io_wr and cmd_mem_wr rise one clock after their advanced strobes (T3 only), and are never high without them.
- R5: data_dir is 1 from T1 through T4 for codes 010 and 110, and 0 at all other times.
- R6: data_en is high in T2, T3 and T4, and every strobe is accompanied by data_en.
- R7: The clock edge after the status is seen at 111 inside a cycle, every strobe is low; one T4 clock with data_en follows, then IDLE.
- R8: The halt code 011 starts no cycle: no addr_latch, no data_en, no strobe.
- R9: A status change between two active codes, or an active code held for many clocks, starts no new cycle and does not change the latched code.
- R10: In reset and after it, until a cycle starts, all outputs are 0.
- R11: A status that is passive for a single clock during T3 and then active again gives T4 followed directly by a new T1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_status | input | 3 | Processor status code |
| cmd_inta | output | 1 | Interrupt acknowledge strobe |
| cmd_io_rd | output | 1 | I/O read strobe |
| cmd_io_wr | output | 1 | I/O write strobe |
| cmd_io_wr_adv | output | 1 | Advanced I/O write strobe |
| cmd_mem_rd | output | 1 | Memory read strobe |
| cmd_mem_wr | output | 1 | Memory write strobe |
| cmd_mem_wr_adv | output | 1 | Advanced memory write strobe |
| addr_latch | output | 1 | Address latch pulse |
| data_en | output | 1 | Data buffer enable |
| data_dir | output | 1 | Data direction, 1 = transmit |

## Verification
The bench builds the block with its default three-bit status width, which is the width every code above is defined in, so all eight codes, including halt and passive, are reachable by both directed and random stimulus. Random hold lengths of one to six clocks reach passive returns inside T1, T2 and long T3 wait states, while directed runs cover back-to-back cycles, active-to-active changes and halt.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_t;

    typedef struct packed {
        logic inta;
        logic io_rd;
        logic io_wr;
        logic io_wr_adv;
        logic mem_rd;
        logic mem_wr;
        logic mem_wr_adv;
    } cmd_t;

    localparam logic [2:0] CODE_INTA  = 3'b000;
    localparam logic [2:0] CODE_IORD  = 3'b001;
    localparam logic [2:0] CODE_IOWR  = 3'b010;
    localparam logic [2:0] CODE_HALT  = 3'b011;
    localparam logic [2:0] CODE_FETCH = 3'b100;
    localparam logic [2:0] CODE_MRD   = 3'b101;
    localparam logic [2:0] CODE_MWR   = 3'b110;
    localparam logic [2:0] CODE_IDLE  = 3'b111;

    function automatic logic code_is_write(input logic [2:0] c);
        return (c == CODE_IOWR) || (c == CODE_MWR);
    endfunction

endpackage

// File: rtl/bus_start_detect.sv
module bus_start_detect #(
    parameter int STATUS_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status,
    output logic                start,
    output logic                passive
);
    import bus_cmd_pkg::*;

    localparam logic [STATUS_W-1:0] PASSIVE_CODE = {STATUS_W{1'b1}};

    logic [STATUS_W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= PASSIVE_CODE;
        else        prev_q <= status;
    end

    always_comb begin
        passive = (status == PASSIVE_CODE);
        start   = (prev_q == PASSIVE_CODE) && !passive &&
                  (status != STATUS_W'(CODE_HALT));
    end

endmodule

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm #(
    parameter int STATUS_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [STATUS_W-1:0]    status,
    input  logic                   start,
    input  logic                   passive,
    output bus_cmd_pkg::phase_t    phase,
    output logic [STATUS_W-1:0]    code
);
    import bus_cmd_pkg::*;

    phase_t              ph_q, ph_d;
    logic [STATUS_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            code_q <= {STATUS_W{1'b1}};
        end else begin
            ph_q <= ph_d;
            if (start && (ph_q == PH_IDLE || ph_q == PH_T4))
                code_q <= status;
        end
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: ph_d = start   ? PH_T1 : PH_IDLE;
            PH_T1:   ph_d = passive ? PH_T4 : PH_T2;
            PH_T2:   ph_d = passive ? PH_T4 : PH_T3;
            PH_T3:   ph_d = passive ? PH_T4 : PH_T3;
            PH_T4:   ph_d = start   ? PH_T1 : PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    assign phase = ph_q;
    assign code  = code_q;

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen #(
    parameter int STATUS_W = 3
) (
    input  bus_cmd_pkg::phase_t    phase,
    input  logic [STATUS_W-1:0]    code,
    output bus_cmd_pkg::cmd_t      cmd,
    output logic                   ale,
    output logic                   den,
    output logic                   dtr
);
    import bus_cmd_pkg::*;

    logic early, full;
    logic [2:0] c3;

    always_comb begin
        c3    = code[2:0];
        early = 1'b0;
        full  = 1'b0;
        ale   = 1'b0;
        den   = 1'b0;
        dtr   = 1'b0;
        unique case (phase)
            PH_IDLE: ;
            PH_T1: begin
                ale = 1'b1;
                dtr = code_is_write(c3);
            end
            PH_T2: begin
                early = 1'b1;
                den   = 1'b1;
                dtr   = code_is_write(c3);
            end
            PH_T3: begin
                early = 1'b1;
                full  = 1'b1;
                den   = 1'b1;
                dtr   = code_is_write(c3);
            end
            PH_T4: begin
                den = 1'b1;
                dtr = code_is_write(c3);
            end
            default: ;
        endcase

        cmd            = '0;
        cmd.inta       = early && (c3 == CODE_INTA);
        cmd.io_rd      = early && (c3 == CODE_IORD);
        cmd.io_wr_adv  = early && (c3 == CODE_IOWR);
        cmd.io_wr      = full  && (c3 == CODE_IOWR);
        cmd.mem_rd     = early && (c3 == CODE_FETCH || c3 == CODE_MRD);
        cmd.mem_wr_adv = early && (c3 == CODE_MWR);
        cmd.mem_wr     = full  && (c3 == CODE_MWR);
    end

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl #(
    parameter int STATUS_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] bus_status,
    output logic                cmd_inta,
    output logic                cmd_io_rd,
    output logic                cmd_io_wr,
    output logic                cmd_io_wr_adv,
    output logic                cmd_mem_rd,
    output logic                cmd_mem_wr,
    output logic                cmd_mem_wr_adv,
    output logic                addr_latch,
    output logic                data_en,
    output logic                data_dir
);
    import bus_cmd_pkg::*;

    logic                start, passive;
    phase_t              phase;
    logic [STATUS_W-1:0] code;
    cmd_t                cmd;

    bus_start_detect #(.STATUS_W(STATUS_W)) u_det (
        .clk(clk), .rst_n(rst_n), .status(bus_status),
        .start(start), .passive(passive)
    );

    bus_phase_fsm #(.STATUS_W(STATUS_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .status(bus_status),
        .start(start), .passive(passive),
        .phase(phase), .code(code)
    );

    bus_cmd_gen #(.STATUS_W(STATUS_W)) u_gen (
        .phase(phase), .code(code), .cmd(cmd),
        .ale(addr_latch), .den(data_en), .dtr(data_dir)
    );

    assign cmd_inta       = cmd.inta;
    assign cmd_io_rd      = cmd.io_rd;
    assign cmd_io_wr      = cmd.io_wr;
    assign cmd_io_wr_adv  = cmd.io_wr_adv;
    assign cmd_mem_rd     = cmd.mem_rd;
    assign cmd_mem_wr     = cmd.mem_wr;
    assign cmd_mem_wr_adv = cmd.mem_wr_adv;

endmodule

// File: rtl/bus_cmd_ctrl_chk.sv
module bus_cmd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_status,
    input logic       cmd_inta,
    input logic       cmd_io_rd,
    input logic       cmd_io_wr,
    input logic       cmd_io_wr_adv,
    input logic       cmd_mem_rd,
    input logic       cmd_mem_wr,
    input logic       cmd_mem_wr_adv,
    input logic       addr_latch,
    input logic       data_en,
    input logic       data_dir
);
    logic any_cmd;
    assign any_cmd = cmd_inta | cmd_io_rd | cmd_io_wr | cmd_io_wr_adv |
                     cmd_mem_rd | cmd_mem_wr | cmd_mem_wr_adv;

    // R1
    one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_inta, cmd_io_rd, cmd_io_wr_adv, cmd_mem_rd, cmd_mem_wr_adv}));

    // R2
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch |=> !addr_latch);

    // R4
    wr_after_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_mem_wr) |-> $past(cmd_mem_wr_adv));

    // R4
    wr_in_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_io_wr |-> cmd_io_wr_adv) and (cmd_mem_wr |-> cmd_mem_wr_adv));

    // R5
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_io_wr_adv | cmd_mem_wr_adv) |-> data_dir);

    // R5
    dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_inta | cmd_io_rd | cmd_mem_rd) |-> !data_dir);

    // R6
    den_with_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |-> data_en);

    // R7
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_status == 3'b111) |=> !any_cmd);

endmodule

bind bus_cmd_ctrl bus_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_status(bus_status),
    .cmd_inta(cmd_inta), .cmd_io_rd(cmd_io_rd), .cmd_io_wr(cmd_io_wr),
    .cmd_io_wr_adv(cmd_io_wr_adv), .cmd_mem_rd(cmd_mem_rd),
    .cmd_mem_wr(cmd_mem_wr), .cmd_mem_wr_adv(cmd_mem_wr_adv),
    .addr_latch(addr_latch), .data_en(data_en), .data_dir(data_dir)
);

// File: tb/sim_bus_cmd_ctrl.sv
module sim_bus_cmd_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] status = 3'b111;
    logic o_inta, o_iord, o_iowr, o_aiowr, o_mrd, o_mwr, o_amwr, o_ale, o_den, o_dtr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    bus_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_status(status),
        .cmd_inta(o_inta), .cmd_io_rd(o_iord), .cmd_io_wr(o_iowr),
        .cmd_io_wr_adv(o_aiowr), .cmd_mem_rd(o_mrd), .cmd_mem_wr(o_mwr),
        .cmd_mem_wr_adv(o_amwr), .addr_latch(o_ale), .data_en(o_den),
        .data_dir(o_dtr)
    );

    // reference: phase 0 idle, 1..4 = T1..T4
    int         m_ph;
    logic [2:0] m_prev, m_code;

    function automatic bit m_start(input logic [2:0] prev, input logic [2:0] s);
        return (prev == 3'b111) && (s != 3'b111) && (s != 3'b011);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph <= 0; m_prev <= 3'b111; m_code <= 3'b111;
        end else begin
            m_prev <= status;
            case (m_ph)
                0, 4: if (m_start(m_prev, status)) begin m_ph <= 1; m_code <= status; end
                      else m_ph <= 0;
                1:    m_ph <= (status == 3'b111) ? 4 : 2;
                default: m_ph <= (status == 3'b111) ? 4 : 3;
            endcase
        end
    end

    function automatic logic [9:0] expect_vec(input int ph, input logic [2:0] c);
        logic early, full, wr;
        early = (ph == 2) || (ph == 3);
        full  = (ph == 3);
        wr    = (c == 3'b010) || (c == 3'b110);
        return {early && c == 3'b000, early && c == 3'b001,
                full && c == 3'b010, early && c == 3'b010,
                early && (c == 3'b100 || c == 3'b101),
                full && c == 3'b110, early && c == 3'b110,
                ph == 1, ph >= 2, (ph != 0) && wr};
    endfunction

    task automatic check(input string what);
        logic [9:0] act, exp;
        string tags;
        act = {o_inta, o_iord, o_iowr, o_aiowr, o_mrd, o_mwr, o_amwr, o_ale, o_den, o_dtr};
        exp = rst_n ? expect_vec(m_ph, m_code) : 10'b0;
        vectors++;
        if (act !== exp) begin
            errors++;
            tags = "";
            if (act[9:3] !== exp[9:3]) tags = {tags, " R1/R3/R4/R7"};
            if (act[2] !== exp[2]) tags = {tags, " R2"};
            if (act[1] !== exp[1]) tags = {tags, " R6"};
            if (act[0] !== exp[0]) tags = {tags, " R5"};
            $display("FAIL %s%s: actual %b expected %b (status %b)", what, tags, act, exp, status);
        end
    endtask

    task automatic step(input logic [2:0] s, input string what);
        @(negedge clk);
        check(what);
        status = s;
    endtask

    task automatic run_cycle(input logic [2:0] c, input int hold, input string what);
        step(c, what);
        for (int i = 0; i < hold; i++) step(c, what);
        step(3'b111, what);
        step(3'b111, what);
        step(3'b111, what);
    endtask

    initial begin
        // R10: reset state
        repeat (3) step(3'b111, "R10 reset");
        @(negedge clk); rst_n = 1'b1;
        repeat (2) step(3'b111, "R10 after reset");
        // R1 R3 R4 R5 R6 R7: every code with a wait state
        for (int c = 0; c < 8; c++) run_cycle(3'(c), 4, "R1 code sweep");
        // R8: halt starts nothing
        run_cycle(3'b011, 5, "R8 halt");
        // R9: active-to-active change, long hold
        step(3'b001, "R9");
        repeat (3) step(3'b110, "R9 change");
        repeat (8) step(3'b000, "R9 hold");
        repeat (3) step(3'b111, "R9 end");
        // R7: passive already in T1
        step(3'b101, "R7 early");
        repeat (3) step(3'b111, "R7 early");
        // R11: single passive clock in T3 then new cycle
        repeat (3) step(3'b110, "R11");
        step(3'b111, "R11");
        repeat (3) step(3'b001, "R11 second");
        repeat (3) step(3'b111, "R11 end");
        // random phase
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 600; k++) begin
            logic [2:0] s;
            int hold;
            s    = ($urandom % 10 < 4) ? 3'b111 : 3'($urandom % 8);
            hold = 1 + int'($urandom % 6);
            for (int j = 0; j < hold; j++) step(s, "R2 random");
        end
        repeat (4) step(3'b111, "tail");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule